// File: doc/BRIEF.md
# Two-Clock FIFO with Two-Pin Fill Code

A first-in first-out buffer for 9-bit words whose write side and read side run on separate, unrelated clocks (or on one clock wired to both inputs). The writer presents a word and pulls its active-low enable low; each rising write-clock edge with the enable low stores one word. The reader pulls its active-low enable low and each rising read-clock edge moves the oldest word into a registered output. Pointers cross between the domains as Gray codes through two-flop synchronizers.

Instead of separate full and empty lines, two status pins carry a four-state fill code. The empty and nearly-empty states are owned by the read clock and change only on its edges. The nearly-full state is owned by the write clock and changes only on its edges, including edges where no write is requested. An active-low master reset, asserted asynchronously, clears the pointers, the output word and the fill code.

Top module: `dcfifo_flags`

## Requirements
- R1: A word on `din` is stored on a rising `wr_clk` edge while `wr_n` is 0; holding `wr_n` at 0 stores one word per write-clock cycle.
- R2: A rising `rd_clk` edge with `rd_n` at 0 and data present loads the oldest stored word into `dout`; words leave in the order they were stored, and `dout` changes on no other edge.
- R3: The code `{f1,f2}` is 2'b00 when empty, 2'b10 when holding 1 to 16 words, 2'b11 between, and 2'b01 when holding DEPTH-16 (2032 at the default depth) or more words.
- R4: The empty and nearly-empty codes are entered and left only on rising `rd_clk` edges; writes made while the read clock is stopped leave the code at empty.
- R5: The nearly-full code is entered and left only on rising `wr_clk` edges; after reads lower the fill, it stays until a write-clock edge, which refreshes it even with `wr_n` at 1.
- R6: A write requested while DEPTH words are stored is ignored: the stored contents are unchanged and no extra word is later read out.
- R7: A read requested while the read side sees no data is ignored and `dout` keeps its value.
- R8: While `rst_n` is 0, `{f1,f2}` is 2'b00 and `dout` is 0.
- R9: The write side sees its own write at the same edge (nearly-full can appear at the edge of the writing write); a write reaches the read-side code by the third `rd_clk` edge and a read reaches the write-side code by the third `wr_clk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| wr_clk | input | 1 | Write clock |
| wr_n | input | 1 | Write enable, active low |
| din | input | 9 | Word to store |
| rd_clk | input | 1 | Read clock |
| rd_n | input | 1 | Read enable, active low |
| dout | output | 9 | Registered read word |
| f1 | output | 1 | Fill code, upper pin |
| f2 | output | 1 | Fill code, lower pin |

## Verification
A read result is due on the read-clock edge that accepts it, so the bench compares `dout` at the falling edge right after; a write's nearly-full effect is due at its own write edge and is sampled on the next falling write-clock edge. Effects that cross domains are allowed three edges of the destination clock, so fill codes are checked only after three rising edges of the owning clock. Ownership is tested by stopping one clock and showing the code does not move, then restarting it, and a monitor requires every code change to occur while the owning clock is high just after its edge.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
    // Two-pin fill code, {f1,f2}
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'b00,
        FILL_LOW   = 2'b10,
        FILL_MID   = 2'b11,
        FILL_HIGH  = 2'b01
    } fill_code_e;
endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int DW    = 9,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
    parameter int DEPTH  = 2048,
    parameter int MARGIN = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          af
);
    localparam logic [AW:0] FULL_CNT = PW'(DEPTH);
    localparam logic [AW:0] AF_LEVEL = PW'(DEPTH - MARGIN);

    typedef struct packed {
        logic [AW:0] wbin;
        logic [AW:0] wgray;
        logic        af;
    } wst_t;

    wst_t st_d, st_q;
    logic [AW:0] rbin;
    logic [AW:0] fill_now;
    logic [AW:0] fill_next;
    logic        accept;

    always_comb begin
        rbin[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s[i];
        fill_now   = st_q.wbin - rbin;
        accept     = !wr_n && (fill_now != FULL_CNT);
        st_d.wbin  = st_q.wbin + {{AW{1'b0}}, accept};
        st_d.wgray = st_d.wbin ^ (st_d.wbin >> 1);
        fill_next  = st_d.wbin - rbin;
        // refreshed on every write edge, enabled or not
        st_d.af    = (fill_next >= AF_LEVEL);
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we    = accept;
    assign waddr = st_q.wbin[AW-1:0];
    assign wgray = st_q.wgray;
    assign af    = st_q.af;

    assert_no_overflow_R6: assert property (@(posedge wclk) disable iff (!rst_n)
        fill_now <= FULL_CNT);
    assert_af_by_write_R5: assert property (@(posedge wclk) disable iff (!rst_n)
        $rose(st_q.af) |-> $past(!wr_n));
    assert_gray_step_R9: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(st_q.wgray ^ $past(st_q.wgray)) <= 1);
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_flag_pkg::*;
#(
    parameter int DW     = 9,
    parameter int DEPTH  = 2048,
    parameter int MARGIN = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output fill_code_e    code
);
    localparam logic [AW:0] LOW_LEVEL = PW'(MARGIN);

    typedef struct packed {
        logic [AW:0]   rbin;
        logic [AW:0]   rgray;
        logic [DW-1:0] dout;
        fill_code_e    code;
    } rst_t;

    rst_t st_d, st_q;
    logic [AW:0] wbin;
    logic [AW:0] fill_now;
    logic [AW:0] fill_next;
    logic        accept;

    always_comb begin
        wbin[AW] = wgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_s[i];
        fill_now   = wbin - st_q.rbin;
        accept     = !rd_n && (fill_now != '0);
        st_d.rbin  = st_q.rbin + {{AW{1'b0}}, accept};
        st_d.rgray = st_d.rbin ^ (st_d.rbin >> 1);
        st_d.dout  = accept ? rdata : st_q.dout;
        fill_next  = wbin - st_d.rbin;
        if (fill_next == '0)             st_d.code = FILL_EMPTY;
        else if (fill_next <= LOW_LEVEL) st_d.code = FILL_LOW;
        else                             st_d.code = FILL_MID;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= FILL_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr = st_q.rbin[AW-1:0];
    assign rgray = st_q.rgray;
    assign dout  = st_q.dout;
    assign code  = st_q.code;

    assert_hold_on_empty_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        (!rd_n && fill_now == '0) |=> $stable(st_q.dout));
    assert_dout_quiet_R2: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_n |=> $stable(st_q.dout));
    assert_empty_by_read_R4: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(st_q.code == FILL_EMPTY) |-> $past(!rd_n));
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
    import fifo_flag_pkg::*;
#(
    parameter int DW     = 9,
    parameter int DEPTH  = 2048,
    parameter int MARGIN = 16
) (
    input  logic          rst_n,
    input  logic          wr_clk,
    input  logic          wr_n,
    input  logic [DW-1:0] din,
    input  logic          rd_clk,
    input  logic          rd_n,
    output logic [DW-1:0] dout,
    output logic          f1,
    output logic          f2
);
    localparam int AW = $clog2(DEPTH);

    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic [DW-1:0] rdata;
    logic          af;
    fill_code_e    rcode, pin_code;

    fifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    fifo_wr_ctl #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_wr (
        .wclk(wr_clk), .rst_n(rst_n), .wr_n(wr_n), .rgray_s(rgray_s),
        .we(we), .waddr(waddr), .wgray(wgray), .af(af)
    );

    fifo_rd_ctl #(.DW(DW), .DEPTH(DEPTH), .MARGIN(MARGIN)) u_rd (
        .rclk(rd_clk), .rst_n(rst_n), .rd_n(rd_n), .wgray_s(wgray_s),
        .rdata(rdata), .raddr(raddr), .rgray(rgray), .dout(dout), .code(rcode)
    );

    fifo_gray_sync #(.W(AW + 1)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    fifo_gray_sync #(.W(AW + 1)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    // read-owned low states take precedence; each source is a register
    always_comb begin
        if (rcode != FILL_MID) pin_code = rcode;
        else if (af)           pin_code = FILL_HIGH;
        else                   pin_code = FILL_MID;
    end

    assign f1 = pin_code[1];
    assign f2 = pin_code[0];

    assert_reset_state_R8: assert property (@(posedge rd_clk)
        !rst_n |-> (pin_code == FILL_EMPTY && dout == '0));
endmodule

// File: tb/dcfifo_flags_tb.sv
module dcfifo_flags_tb;
    localparam int DW = 9;
    localparam int DEPTH = 2048;

    logic wr_clk = 0, rd_clk = 0, wrun = 1, rrun = 1;
    logic rst_n = 0, wr_n = 1, rd_n = 1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic f1, f2;

    int checks = 0, fails = 0, v = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] last_out = '0;
    logic [1:0] prev_code = 2'b00;
    logic mon_on = 0;
    logic wdone = 0;

    dcfifo_flags u_dut (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_n(wr_n), .din(din),
        .rd_clk(rd_clk), .rd_n(rd_n), .dout(dout), .f1(f1), .f2(f2)
    );

    always #4 if (wrun || wr_clk) wr_clk = ~wr_clk;
    always #7 if (rrun || rd_clk) rd_clk = ~rd_clk;

    task automatic check(string r, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic flags_is(string r, logic [1:0] exp);
        check(r, {14'd0, f1, f2}, {14'd0, exp});
    endtask

    task automatic wr_words(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_n = 0;
            din = DW'(v);
            if (q.size() < DEPTH) q.push_back(DW'(v));
            v++;
        end
        @(negedge wr_clk);
        wr_n = 1;
    endtask

    task automatic rd_words(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_n = 0;
            @(negedge rd_clk);
            rd_n = 1;
            if (q.size() > 0) last_out = q.pop_front();
            check("R2/R7 read word", {7'd0, dout}, {7'd0, last_out});
        end
    endtask

    task automatic rsettle();
        repeat (3) @(posedge rd_clk);
        @(negedge rd_clk);
    endtask

    task automatic wsettle();
        repeat (3) @(posedge wr_clk);
        @(negedge wr_clk);
    endtask

    // R4/R5 ownership: every code change lands while the owning clock is high
    always @(f1 or f2) begin
        if (mon_on && rst_n === 1'b1) begin
            if (prev_code == 2'b00 || prev_code == 2'b10 ||
                {f1, f2} == 2'b00 || {f1, f2} == 2'b10)
                check("R4 change on read clock", {15'd0, rd_clk}, 16'd1);
            else
                check("R5 change on write clock", {15'd0, wr_clk}, 16'd1);
        end
        prev_code = {f1, f2};
    end

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge rd_clk);
        // R8: reset state
        flags_is("R8 reset code", 2'b00);
        check("R8 reset dout", {7'd0, dout}, 16'd0);
        #3 rst_n = 1;
        @(negedge rd_clk);
        prev_code = {f1, f2};
        mon_on = 1;

        // R7: read while empty leaves dout alone
        rd_words(3);
        flags_is("R7 still empty", 2'b00);

        // R4: write with read clock stopped, code stays empty
        @(negedge rd_clk); rrun = 0;
        wr_words(1);
        wsettle();
        flags_is("R4 no read edge keeps empty", 2'b00);
        rrun = 1;
        rsettle();
        flags_is("R3/R9 one word low", 2'b10);

        wr_words(15);
        rsettle();
        flags_is("R3 sixteen words low", 2'b10);
        wr_words(1);
        rsettle();
        flags_is("R3 seventeen words mid", 2'b11);

        // R1/R2: order through a partial drain
        rd_words(16);
        rsettle();
        flags_is("R3 back to one word", 2'b10);
        rd_words(1);
        rsettle();
        flags_is("R3 drained empty", 2'b00);

        // R3/R9: nearly-full threshold at the writing edge
        wr_words(2031);
        rsettle();
        wsettle();
        flags_is("R3 2031 words mid", 2'b11);
        wr_words(1);
        flags_is("R9 nearly full at own edge", 2'b01);

        // R5: reads with write clock stopped keep nearly-full
        @(negedge wr_clk); wrun = 0;
        rd_words(2);
        rsettle();
        flags_is("R5 no write edge keeps nearly full", 2'b01);
        wrun = 1;
        wsettle();
        flags_is("R5 idle write edge refreshes", 2'b11);

        // R6: overfill with read clock stopped
        @(negedge rd_clk); rrun = 0;
        wr_words(21);
        rrun = 1;
        rsettle();
        flags_is("R6 full shows nearly full", 2'b01);
        check("R6 model depth", 16'(q.size()), 16'(DEPTH));
        rd_words(DEPTH);
        rd_words(1);
        rsettle();
        flags_is("R6/R7 empty after drain", 2'b00);

        // R1/R2/R5: streaming with unrelated clocks
        fork
            begin
                for (int i = 0; i < 3000; i++) begin
                    @(negedge wr_clk);
                    if ({f1, f2} != 2'b01) begin
                        wr_n = 0; din = DW'(v); q.push_back(DW'(v)); v++;
                    end else begin
                        wr_n = 1;
                    end
                end
                @(negedge wr_clk);
                wr_n = 1;
                wdone = 1;
            end
            begin
                logic pend;
                pend = 0;
                while (!(wdone && q.size() == 0 && !pend)) begin
                    @(negedge rd_clk);
                    if (pend) begin
                        last_out = q.pop_front();
                        check("R2 streamed order", {7'd0, dout}, {7'd0, last_out});
                    end
                    if ({f1, f2} != 2'b00) begin
                        rd_n = 0; pend = 1;
                    end else begin
                        rd_n = 1; pend = 0;
                    end
                end
                rd_n = 1;
            end
        join
        rsettle();
        flags_is("R1 stream ends empty", 2'b00);

        mon_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule